// File: doc/BRIEF.md
# Wait-State Slave Ready Generator

This block is the front end of a slow bus slave on a single-master AHB-Lite bus. It records the address-phase control of each transfer and then paces the data phase with a latency counter. Because of this, a slow target such as a flash model can stretch every access by a fixed, parameterised number of wait states. The ready output it drives goes to the interconnect. The interconnect returns the ready of whichever slave owns the current data phase on the shared ready input. The block uses that shared input, never its own output, to decide when to take in a new address phase.

Waits are inserted only for transfers that were selected and active when they were accepted. Idle, busy and unselected cycles leave the ready output high. A small array, loaded with a fixed pattern at reset, supplies the read data. That data is registered in the same clock edge that raises ready, so data and ready appear together. When the wait count is zero, the ready output is a constant high and the read data comes straight from the array.

Top module: `ws_ready_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, ready_o=1, dphase_o=0, done_o=0 and rdata_o=0. This also applies when reset arrives in the middle of an access.
- R2: When sel_i=1, trans_i is NONSEQ (2'b10) or SEQ (2'b11), and ready_i=1 at a clock edge, ready_o is low for exactly WAIT_CYCLES cycles after that edge and then high. With the default of 3, ready_o is low for three cycles and high in the fourth data-phase cycle.
- R3: ready_o is high in exactly one data-phase cycle per access, and done_o is high in that cycle only.
- R4: A cycle with trans_i IDLE (2'b00) or BUSY (2'b01), or with sel_i=0, starts no access. ready_o stays high and dphase_o stays 0.
- R5: Address-phase inputs are taken in only at a clock edge where ready_i=1. A selected NONSEQ presented only while ready_i=0 starts no access.
- R6: In the completion cycle of a read, rdata_o equals 32'hC0DE0000 + i*32'h101, where i is addr_i[5:2] of that access. rdata_o is 0 in every other cycle.
- R7: A write (write_i=1) follows the same wait timing as a read, and rdata_o stays 0 throughout.
- R8: An address phase accepted in a completion cycle starts its access at once. ready_o is low again in the very next cycle.
- R9: With WAIT_CYCLES=0, ready_o is constantly 1. The data phase is a single cycle, and read data is valid in it.
- R10: dphase_o is 1 in every data-phase cycle of an accepted access, both the wait cycles and the completion cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Slave select from the address decoder |
| trans_i | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| write_i | input | 1 | Transfer direction, 1 = write |
| addr_i | input | AW | Byte address |
| ready_i | input | 1 | Shared bus ready from the interconnect |
| ready_o | output | 1 | This slave's ready; low inserts a wait state |
| dphase_o | output | 1 | An accepted access is in its data phase |
| done_o | output | 1 | Completion strobe for the current access |
| rdata_o | output | DW | Read data, valid on read completion |

## Verification
The main stimulus is a single read issued from an idle bus. That read pins down the exact cycle in which ready rises and the data word that arrives with it. A write followed at once by a read, with the read held on the bus across the wait cycles, has two purposes. It shows that the write keeps the same timing without returning data. It also shows that the held address is taken only in the completion cycle. Selected IDLE and BUSY cycles and an unselected NONSEQ separate qualified waits from waits on any bus activity. A selected NONSEQ offered while another slave stalls the shared ready shows whether capture is gated on the shared input or on the slave's own output.

// File: rtl/slv_pkg.sv
package slv_pkg;
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  function automatic logic is_active(input logic [1:0] trans);
    return (trans == TR_NSEQ) || (trans == TR_SEQ);
  endfunction

  function automatic logic [31:0] store_word(input int idx);
    return 32'hC0DE_0000 + 32'(idx) * 32'h0000_0101;
  endfunction
endpackage

// File: rtl/slv_addr_capture.sv
module slv_addr_capture #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          sel_i,
  input  logic [1:0]    trans_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  output logic          start_o,
  output logic          dphase_o,
  output logic          write_o,
  output logic [AW-1:0] addr_o
);
  logic          sel_q, act_q, write_q;
  logic [AW-1:0] addr_q;

  assign start_o = ready_i && sel_i && slv_pkg::is_active(trans_i);

  // capture on the shared bus ready only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      act_q   <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
    end else if (ready_i) begin
      sel_q   <= sel_i;
      act_q   <= slv_pkg::is_active(trans_i);
      write_q <= write_i;
      addr_q  <= addr_i;
    end
  end

  assign dphase_o = sel_q && act_q;
  assign write_o  = write_q;
  assign addr_o   = addr_q;

  assert_hold_on_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(sel_q) && $stable(act_q) && $stable(write_q) && $stable(addr_q)));
endmodule

// File: rtl/slv_wait_timer.sv
module slv_wait_timer #(
  parameter int WAITS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic load_o
);
  if (WAITS == 0) begin : g_zero
    assign ready_o = 1'b1;
    assign load_o  = 1'b0;
  end else begin : g_count
    localparam int CW = $clog2(WAITS + 1);
    logic          ready_q;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   low_run_q;

    // ready registered: raised one edge ahead, as the count hits its last value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ready_q <= 1'b1;
        cnt_q   <= '0;
      end else if (start_i) begin
        ready_q <= 1'b0;
        cnt_q   <= CW'(WAITS);
      end else if (!ready_q) begin
        if (cnt_q == CW'(1)) ready_q <= 1'b1;
        cnt_q <= cnt_q - CW'(1);
      end
    end

    assign ready_o = ready_q;
    assign load_o  = !ready_q && (cnt_q == CW'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      low_run_q <= '0;
      else if (ready_q) low_run_q <= '0;
      else              low_run_q <= low_run_q + 1'b1;
    end

    assert_start_waits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> !ready_o);
    assert_bounded_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ready_q |-> (low_run_q < (CW+1)'(WAITS)));
  end
endmodule

// File: rtl/slv_store.sv
module slv_store #(
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter bit ZERO_WAIT = 1'b0,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(slv_pkg::store_word(i));
    end
  end

  if (ZERO_WAIT) begin : g_comb
    logic unused_load;
    assign unused_load = load_i;
    assign data_o = mem_q[idx_i];
  end else begin : g_reg
    logic [DW-1:0] rd_q;
    // data lands on the same edge that raises ready
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rd_q <= '0;
      else if (load_i) rd_q <= mem_q[idx_i];
    end
    assign data_o = rd_q;
  end
endmodule

// File: rtl/ws_ready_gen.sv
module ws_ready_gen #(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int DEPTH       = 16,
  parameter int WAIT_CYCLES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [1:0]    trans_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ready_i,
  output logic          ready_o,
  output logic          dphase_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  localparam int IW = $clog2(DEPTH);

  logic          start, dphase, write_q, load;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] store_data;
  logic          unused_addr;

  slv_addr_capture #(.AW(AW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (ready_i),
    .sel_i    (sel_i),
    .trans_i  (trans_i),
    .write_i  (write_i),
    .addr_i   (addr_i),
    .start_o  (start),
    .dphase_o (dphase),
    .write_o  (write_q),
    .addr_o   (addr_q)
  );

  slv_wait_timer #(.WAITS(WAIT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ready_o (ready_o),
    .load_o  (load)
  );

  slv_store #(.DW(DW), .DEPTH(DEPTH), .ZERO_WAIT(WAIT_CYCLES == 0)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .idx_i  (addr_q[IW+1:2]),
    .data_o (store_data)
  );

  assign unused_addr = ^{addr_q[AW-1:IW+2], addr_q[1:0]};

  assign dphase_o = dphase;
  assign done_o   = dphase && ready_o;
  assign rdata_o  = (done_o && !write_q) ? store_data : '0;

  assert_idle_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dphase_o |-> ready_o);
  assert_single_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((WAIT_CYCLES != 0) && done_o) |=> !done_o);
  assert_done_in_dphase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> dphase_o);
endmodule

// File: tb/ws_ready_gen_test.sv
`timescale 1ns/1ps
module ws_ready_gen_test;
  typedef struct packed {
    logic       sel;
    logic [1:0] trans;
    logic       wr;
    logic [3:0] idx;
    logic       stall;
    logic       e_rdy;
    logic       e_dph;
    logic       e_done;
    logic       e_rd;
    logic [3:0] e_idx;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 0 idle
    '{1'b1, 2'b10, 1'b0, 4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 1 read 5 addr phase
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 2 wait R2
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 3 wait
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 4 wait
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5}, // 5 complete R3 R6
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 6 ready stays high
    '{1'b1, 2'b00, 1'b0, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 7 selected IDLE R4
    '{1'b1, 2'b01, 1'b0, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 8 selected BUSY R4
    '{1'b0, 2'b10, 1'b0, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 9 unselected NONSEQ R4
    '{1'b1, 2'b10, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 10 NONSEQ under stall R5
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 11 not taken R5
    '{1'b1, 2'b11, 1'b1, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}, // 12 SEQ write R7
    '{1'b1, 2'b10, 1'b0, 4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 13 read held
    '{1'b1, 2'b10, 1'b0, 4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 14
    '{1'b1, 2'b10, 1'b0, 4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 15
    '{1'b1, 2'b10, 1'b0, 4'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0}, // 16 write done, rdata 0
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 17 back-to-back R8
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 18
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // 19
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7}, // 20 read 7 done
    '{1'b0, 2'b00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}  // 21
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, stall = 1'b0;
  logic [1:0]  trans = 2'b00;
  logic [15:0] addr = '0;
  logic        rdy, dph, done, rdy_in;
  logic [31:0] rdata;
  logic        zrdy, zdph, zdone, zrdy_in;
  logic [31:0] zrdata;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  // interconnect model: data-phase owner drives the shared ready
  assign rdy_in  = dph  ? rdy  : !stall;
  assign zrdy_in = zdph ? zrdy : !stall;

  ws_ready_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .trans_i(trans), .write_i(wr),
    .addr_i(addr), .ready_i(rdy_in), .ready_o(rdy), .dphase_o(dph),
    .done_o(done), .rdata_o(rdata)
  );

  ws_ready_gen #(.WAIT_CYCLES(0)) uut_zw (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .trans_i(trans), .write_i(wr),
    .addr_i(addr), .ready_i(zrdy_in), .ready_o(zrdy), .dphase_o(zdph),
    .done_o(zdone), .rdata_o(zrdata)
  );

  function automatic logic [31:0] word_of(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h101;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] t, input logic w, input int i);
    sel = s; trans = t; wr = w; addr = 16'(i) << 2;
  endtask

  initial begin
    #(20 * 20000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #35;
    chk("R1 ready in reset", 32'(rdy), 32'd1);
    chk("R1 dphase in reset", 32'(dph), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k].sel, VEC[k].trans, VEC[k].wr, int'(VEC[k].idx));
      stall = VEC[k].stall;
      #1;
      chk($sformatf("R2 R8 ready v%0d", k), 32'(rdy), 32'(VEC[k].e_rdy));
      chk($sformatf("R10 dphase v%0d", k), 32'(dph), 32'(VEC[k].e_dph));
      chk($sformatf("R3 done v%0d", k), 32'(done), 32'(VEC[k].e_done));
      chk($sformatf("R6 R7 rdata v%0d", k), rdata,
          VEC[k].e_rd ? word_of(int'(VEC[k].e_idx)) : 32'd0);
      chk($sformatf("R9 zero-wait ready v%0d", k), 32'(zrdy), 32'd1);
    end

    // reset in the middle of an access
    @(negedge clk); drive(1'b1, 2'b10, 1'b0, 4);
    @(negedge clk); drive(1'b0, 2'b00, 1'b0, 0);
    #1 chk("R2 wait before reset", 32'(rdy), 32'd0);
    #4 rst_n = 1'b0;
    #1;
    chk("R1 ready after mid reset", 32'(rdy), 32'd1);
    chk("R1 dphase after mid reset", 32'(dph), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 ready after release", 32'(rdy), 32'd1);

    // zero-wait variant: single-cycle data phase with data
    @(negedge clk); drive(1'b1, 2'b10, 1'b0, 9);
    #1 chk("R9 zw addr phase dphase", 32'(zdph), 32'd0);
    @(negedge clk); drive(1'b0, 2'b00, 1'b0, 0);
    #1;
    chk("R9 zw ready", 32'(zrdy), 32'd1);
    chk("R9 zw done", 32'(zdone), 32'd1);
    chk("R9 zw rdata", zrdata, word_of(9));
    @(negedge clk);
    #1 chk("R9 zw dphase ends", 32'(zdph), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule